// File: doc/BRIEF.md
# Bus Address/Data Parity Generator and Checker

This block covers the parity rules of a shared 32-bit multiplexed address/data bus with an optional second 32-bit lane. Each cycle it registers the sampled address/data and command/byte-enable lines. In the next cycle it produces, or checks, one parity bit per lane. A lane passes when the count of ones across its data bits, its four command/byte-enable bits and its parity bit is even. When the local agent owns the bus phase, the block drives the parity bits. When another agent owns it, the block compares the parity it receives with the value it computes.

A mismatch in a received data phase raises the active-low data-error strobe. A mismatch in a received address phase raises the active-low system-error strobe. Each strobe lasts one clock and is gated by enable bits from the command register. Every detected mismatch sets a sticky status flag, whatever the enables are set to. A one-cycle clear pulse resets the flag.

The control core is a five-state machine. The state records what the previous cycle was: ST_IDLE (no phase), ST_GEN_ADDR or ST_GEN_DATA (the local agent drove an address or data phase) and ST_CHK_ADDR or ST_CHK_DATA (another agent drove it). Every state can move to every state on each clock. The next state is chosen from the current inputs:
- no phase flag selects ST_IDLE;
- the address flag with local drive selects ST_GEN_ADDR;
- the data flag alone with local drive selects ST_GEN_DATA;
- the address flag without local drive selects ST_CHK_ADDR;
- the data flag alone without local drive selects ST_CHK_DATA.

If both phase flags are high, the address flag wins. The 64-bit negotiation flag is registered alongside the state.

Top module: `bus_parity_unit`

## Requirements
- R1: In the cycle after a phase driven by the local agent (address or data), par_oe[0] is 1 and par_out[0] equals the XOR of ad[31:0] and cbe_n[3:0] as sampled in that phase.
- R2: In the cycle after a locally driven data phase with wide_xfer=1, par_oe[1] is 1 and par_out[1] equals the XOR of ad[63:32] and cbe_n[7:4]. After an address phase, or with wide_xfer=0, par_oe[1] and par_out[1] are 0.
- R3: Suppose another agent drives a data phase in cycle k and par_in[0] in cycle k+1 makes the lower lane's count of ones odd. With perr_en=1, perr_n is 0 in cycle k+2 only.
- R4: The upper lane (par_in[1] against ad[63:32] and cbe_n[7:4]) is checked only in received data phases with wide_xfer=1. An upper mismatch in an address phase or in a 32-bit data phase causes no strobe and does not set the status flag.
- R5: With perr_en=0, data-phase mismatches never drive perr_n low.
- R6: A lower-lane mismatch in a received address phase drives serr_n low for the single cycle k+2, only if serr_en=1 and perr_en=1. An address error never drives perr_n.
- R7: par_in is ignored in the cycle after a locally driven phase: a wrong value there causes no strobe and no status change.
- R8: par_err_stat is set by every mismatch that is checked, whatever perr_en and serr_en are. It holds until stat_clr=1 is sampled, and it reads 0 the cycle after that. If a new mismatch and stat_clr fall in the same cycle, the flag is set.
- R9: After reset, perr_n=1, serr_n=1, par_err_stat=0 and par_oe=0.
- R10: A cycle with neither phase flag set generates no parity (par_oe=0) and checks nothing in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | 64 | Sampled address/data bus, lane 0 = [31:0] |
| cbe_n | input | 8 | Sampled command/byte-enable bus, lane 0 = [3:0] |
| par_in | input | 2 | Received parity per lane, one cycle after the data it covers |
| phase_addr | input | 1 | Current cycle is an address phase |
| phase_data | input | 1 | Current cycle is a data phase |
| local_drive | input | 1 | The local agent drives this phase |
| wide_xfer | input | 1 | 64-bit transfer negotiated |
| perr_en | input | 1 | Parity-response enable |
| serr_en | input | 1 | System-error report enable |
| stat_clr | input | 1 | Clear pulse for the sticky status flag |
| par_out | output | 2 | Generated parity per lane |
| par_oe | output | 2 | Per-lane parity drive valid |
| perr_n | output | 1 | Data parity error strobe, active low |
| serr_n | output | 1 | Address parity (system) error strobe, active low |
| par_err_stat | output | 1 | Sticky detected-parity-error flag |

## Verification
The two events that can land in the same cycle are a new mismatch reaching the sticky flag and the clear pulse. The bench sends a corrupted received data phase and raises stat_clr in the cycle where par_in arrives, so that both are sampled on the same edge. It then expects the flag to read 1 a cycle later, and to read 0 only after a following clear that arrives with no error. The vector loop also puts a clear in the cycle right after each strobe, to show that the strobe has already returned high and that the flag drops.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_GEN_ADDR = 3'd1,
        ST_GEN_DATA = 3'd2,
        ST_CHK_ADDR = 3'd3,
        ST_CHK_DATA = 3'd4
    } phase_st_e;

    function automatic phase_st_e next_phase(input logic is_addr,
                                             input logic is_data,
                                             input logic drive);
        phase_st_e r;
        if (is_addr)      r = drive ? ST_GEN_ADDR : ST_CHK_ADDR;
        else if (is_data) r = drive ? ST_GEN_DATA : ST_CHK_DATA;
        else              r = ST_IDLE;
        return r;
    endfunction

endpackage

// File: rtl/bpu_lane_parity.sv
module bpu_lane_parity #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [DATA_W-1:0] lane_ad,
    input  logic [BE_W-1:0]   lane_be,
    output logic              lane_par
);
    // Even parity: parity bit equals XOR of all covered lines
    always_comb begin
        lane_par = (^lane_ad) ^ (^lane_be);
    end
endmodule

// File: rtl/bpu_phase_fsm.sv
module bpu_phase_fsm
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase_addr,
    input  logic phase_data,
    input  logic local_drive,
    input  logic wide_xfer,
    output logic gen_addr,
    output logic gen_data,
    output logic chk_addr,
    output logic chk_data,
    output logic wide_q
);
    phase_st_e state_q;
    phase_st_e state_d;

    always_comb begin
        state_d = next_phase(phase_addr, phase_data, local_drive);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wide_q  <= wide_xfer;
        end
    end

    // Output decode
    always_comb begin
        gen_addr = 1'b0;
        gen_data = 1'b0;
        chk_addr = 1'b0;
        chk_data = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_GEN_ADDR: gen_addr = 1'b1;
            ST_GEN_DATA: gen_data = 1'b1;
            ST_CHK_ADDR: chk_addr = 1'b1;
            ST_CHK_DATA: chk_data = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/bpu_err_report.sv
module bpu_err_report (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_err,
    input  logic data_err,
    input  logic perr_en,
    input  logic serr_en,
    input  logic stat_clr,
    output logic perr_n,
    output logic serr_n,
    output logic par_err_stat
);
    logic perr_q;
    logic serr_q;
    logic stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perr_q <= 1'b0;
            serr_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            perr_q <= data_err & perr_en;
            serr_q <= addr_err & perr_en & serr_en;
            // A new error outranks a clear in the same cycle
            stat_q <= (stat_q & ~stat_clr) | addr_err | data_err;
        end
    end

    always_comb begin
        perr_n       = ~perr_q;
        serr_n       = ~serr_q;
        par_err_stat = stat_q;
    end
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bpu_pkg::*;
#(
    parameter int LANE_W    = 32,
    parameter int BE_W      = 4,
    parameter int NUM_LANES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [LANE_W*NUM_LANES-1:0]     ad,
    input  logic [BE_W*NUM_LANES-1:0]       cbe_n,
    input  logic [NUM_LANES-1:0]            par_in,
    input  logic                            phase_addr,
    input  logic                            phase_data,
    input  logic                            local_drive,
    input  logic                            wide_xfer,
    input  logic                            perr_en,
    input  logic                            serr_en,
    input  logic                            stat_clr,
    output logic [NUM_LANES-1:0]            par_out,
    output logic [NUM_LANES-1:0]            par_oe,
    output logic                            perr_n,
    output logic                            serr_n,
    output logic                            par_err_stat
);
    localparam int AD_W  = LANE_W * NUM_LANES;
    localparam int CBE_W = BE_W * NUM_LANES;

    logic [AD_W-1:0]      ad_q;
    logic [CBE_W-1:0]     cbe_q;
    logic [NUM_LANES-1:0] lane_par;
    logic [NUM_LANES-1:0] lane_gen;
    logic [NUM_LANES-1:0] lane_chk;
    logic [NUM_LANES-1:0] lane_mis;
    logic gen_addr, gen_data, chk_addr, chk_data, wide_q;
    logic addr_err, data_err;

    // Bus values covered by the parity that arrives one clock later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ad_q  <= '0;
            cbe_q <= '0;
        end else begin
            ad_q  <= ad;
            cbe_q <= cbe_n;
        end
    end

    bpu_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_addr  (phase_addr),
        .phase_data  (phase_data),
        .local_drive (local_drive),
        .wide_xfer   (wide_xfer),
        .gen_addr    (gen_addr),
        .gen_data    (gen_data),
        .chk_addr    (chk_addr),
        .chk_data    (chk_data),
        .wide_q      (wide_q)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        bpu_lane_parity #(.DATA_W(LANE_W), .BE_W(BE_W)) u_par (
            .lane_ad  (ad_q[l*LANE_W +: LANE_W]),
            .lane_be  (cbe_q[l*BE_W +: BE_W]),
            .lane_par (lane_par[l])
        );
        if (l == 0) begin : g_base
            // Base lane covers command in address phases too
            assign lane_gen[l] = gen_addr | gen_data;
            assign lane_chk[l] = chk_addr | chk_data;
        end else begin : g_upper
            // Upper lanes carry byte enables only in wide data phases
            assign lane_gen[l] = gen_data & wide_q;
            assign lane_chk[l] = chk_data & wide_q;
        end
    end

    always_comb begin
        par_oe   = lane_gen;
        par_out  = lane_par & lane_gen;
        lane_mis = (lane_par ^ par_in) & lane_chk;
        addr_err = chk_addr & lane_mis[0];
        data_err = chk_data & (|lane_mis);
    end

    bpu_err_report u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_err     (addr_err),
        .data_err     (data_err),
        .perr_en      (perr_en),
        .serr_en      (serr_en),
        .stat_clr     (stat_clr),
        .perr_n       (perr_n),
        .serr_n       (serr_n),
        .par_err_stat (par_err_stat)
    );
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
    parameter int NUM_LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 phase_addr,
    input logic                 phase_data,
    input logic                 local_drive,
    input logic                 perr_en,
    input logic                 serr_en,
    input logic                 stat_clr,
    input logic [NUM_LANES-1:0] par_oe,
    input logic                 perr_n,
    input logic                 serr_n,
    input logic                 par_err_stat
);
    a_r3_perr_single: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |=> perr_n);

    a_r6_serr_single: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |=> serr_n);

    a_r5_perr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(perr_en, 2));

    a_r6_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> ($past(serr_en, 2) && $past(perr_en, 2)));

    a_r6_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!perr_n && !serr_n));

    a_r8_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(par_err_stat) |-> $past(stat_clr));

    a_r1_gen_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe[0] |-> $past(local_drive && (phase_addr || phase_data)));

    a_r2_upper_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(par_oe) > 0 |-> par_oe[0]);
endmodule

bind bus_parity_unit bpu_checker #(.NUM_LANES(NUM_LANES)) u_bpu_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_addr   (phase_addr),
    .phase_data   (phase_data),
    .local_drive  (local_drive),
    .perr_en      (perr_en),
    .serr_en      (serr_en),
    .stat_clr     (stat_clr),
    .par_oe       (par_oe),
    .perr_n       (perr_n),
    .serr_n       (serr_n),
    .par_err_stat (par_err_stat)
);

// File: tb/test_bus_parity_unit.sv
`timescale 1ns/1ps
module test_bus_parity_unit;

    typedef struct packed {
        logic [63:0] ad;
        logic [7:0]  be;
        logic [1:0]  kind;    // 0 idle, 1 address, 2 data
        logic        drv;
        logic        wide;
        logic        pen;
        logic        sen;
        logic        bad_lo;
        logic        bad_hi;
        logic        x_perr;
        logic        x_serr;
        logic        x_stat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{64'h0000_0000_1234_5678, 8'hF0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h0000_0000_89AB_CDEF, 8'hF3, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{64'hDEAD_BEEF_0F0F_1111, 8'h5A, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{64'hDEAD_BEEF_0F0F_1111, 8'h5A, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{64'h0000_0000_A000_0004, 8'h07, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{64'h0000_0000_A000_0004, 8'h07, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h0000_0000_A000_0004, 8'h06, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h0000_0000_0000_0001, 8'h0E, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h1357_9BDF_2468_ACE0, 8'h3C, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{64'hFFFF_0000_C0DE_0001, 8'hA6, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h7777_7777_4000_0000, 8'h1B, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{64'h0000_0000_FFFF_0000, 8'h00, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ad = '0;
    logic [7:0]  cbe_n = '0;
    logic [1:0]  par_in = '0;
    logic        phase_addr = 1'b0, phase_data = 1'b0, local_drive = 1'b0;
    logic        wide_xfer = 1'b0, perr_en = 1'b0, serr_en = 1'b0, stat_clr = 1'b0;
    logic [1:0]  par_out, par_oe;
    logic        perr_n, serr_n, par_err_stat;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_parity_unit i_bus_parity_unit (
        .clk (clk), .rst_n (rst_n), .ad (ad), .cbe_n (cbe_n), .par_in (par_in),
        .phase_addr (phase_addr), .phase_data (phase_data), .local_drive (local_drive),
        .wide_xfer (wide_xfer), .perr_en (perr_en), .serr_en (serr_en),
        .stat_clr (stat_clr), .par_out (par_out), .par_oe (par_oe),
        .perr_n (perr_n), .serr_n (serr_n), .par_err_stat (par_err_stat)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Phase in cycle k, parity in k+1, strobes observed in k+2
    task automatic do_vec(input vec_t v, input logic clr_mid, input logic tail);
        logic lo, hi, oe_lo, oe_hi;
        lo    = (^v.ad[31:0]) ^ (^v.be[3:0]);
        hi    = (^v.ad[63:32]) ^ (^v.be[7:4]);
        oe_lo = v.drv && (v.kind != 2'd0);
        oe_hi = v.drv && (v.kind == 2'd2) && v.wide;
        @(negedge clk);
        ad = v.ad; cbe_n = v.be;
        phase_addr = (v.kind == 2'd1); phase_data = (v.kind == 2'd2);
        local_drive = v.drv; wide_xfer = v.wide; perr_en = v.pen; serr_en = v.sen;
        @(negedge clk);
        phase_addr = 1'b0; phase_data = 1'b0; local_drive = 1'b0; wide_xfer = 1'b0;
        par_in = {hi ^ v.bad_hi, lo ^ v.bad_lo};
        stat_clr = clr_mid;
        check("R1/R10 par_oe[0]", 64'(par_oe[0]), 64'(oe_lo));
        check("R1 par_out[0]", 64'(par_out[0]), 64'(oe_lo & lo));
        check("R2 par_oe[1]", 64'(par_oe[1]), 64'(oe_hi));
        check("R2 par_out[1]", 64'(par_out[1]), 64'(oe_hi & hi));
        @(negedge clk);
        stat_clr = 1'b0; par_in = '0;
        check("R3/R4/R5/R7 perr_n", 64'(perr_n), 64'(!v.x_perr));
        check("R6 serr_n", 64'(serr_n), 64'(!v.x_serr));
        check("R8 status set", 64'(par_err_stat), 64'(v.x_stat));
        if (tail) begin
            stat_clr = 1'b1;
            @(negedge clk);
            stat_clr = 1'b0;
            check("R3 perr_n one cycle", 64'(perr_n), 64'd1);
            check("R6 serr_n one cycle", 64'(serr_n), 64'd1);
            check("R8 status cleared", 64'(par_err_stat), 64'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 perr_n reset", 64'(perr_n), 64'd1);
        check("R9 serr_n reset", 64'(serr_n), 64'd1);
        check("R9 status reset", 64'(par_err_stat), 64'd0);
        check("R9 par_oe reset", 64'(par_oe), 64'd0);

        for (int i = 0; i < NV; i++) do_vec(VEC[i], 1'b0, 1'b1);

        // R8: flag holds across idle cycles
        e = VEC[1];
        do_vec(e, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check("R8 sticky hold", 64'(par_err_stat), 64'd1);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        check("R8 clear after hold", 64'(par_err_stat), 64'd0);

        // R8: new error and clear on the same edge, set wins
        do_vec(e, 1'b1, 1'b0);
        check("R8 set beats clear", 64'(par_err_stat), 64'd1);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        check("R8 clear alone", 64'(par_err_stat), 64'd0);

        // R7: wrong parity after a driven data phase, disabled report path irrelevant
        e = VEC[8]; e.pen = 1'b0;
        do_vec(e, 1'b0, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule